// File: doc/BRIEF.md
# Probabilistic Confidence Counter Bank

This block holds one small confidence counter per entry of a value predictor. The pipeline queries an entry by index and learns whether that entry's prediction is trustworthy enough to be consumed. When the predicted instruction retires, the pipeline reports the outcome for the same index: correct or wrong. A wrong outcome clears the counter at once. A correct outcome moves the counter one step up, but only if a pseudo-random draw succeeds. The chance of success depends on the counter's current level, so a 3-bit counter needs as many correct outcomes to saturate as a much wider plain counter would.

A free-running 16-bit linear feedback shift register supplies the random bits. Its seed is sampled while reset is held, so a test environment can predict every draw. A mode input selects the step probabilities. One profile suits recovery by squashing at retirement. A second, less strict profile suits selective replay. A plain mode turns the bank into an ordinary saturating counter.

Top module: `conf_ctr_bank`

## Requirements
- R1: While rst_ni is low every counter is cleared to 0 and the shift register is loaded with seed_i; a seed of 0 is replaced by 16'h0001.
- R2: A read request (rd_en_i) in one cycle produces rd_valid_o=1 in the next cycle, with rd_level_o equal to the counter at rd_idx_i and rd_conf_o=1 exactly when that level is 7; without a request rd_valid_o is 0.
- R3: When a read and an update address the same index in the same cycle, the read returns the level from before the update.
- R4: An update with upd_hit_i=0 sets the addressed counter to 0 from any level.
- R5: An update with upd_hit_i=1 on a counter at 7 leaves it at 7.
- R6: In plain mode (mode_i = 0 or 3) every update with upd_hit_i=1 raises a counter below 7 by exactly one.
- R7: In mode_i = 1 a correct outcome raises level 0 with certainty, levels 1 to 4 with chance 1/16, and levels 5 and 6 with chance 1/32.
- R8: In mode_i = 2 a correct outcome raises level 0 with certainty, levels 1 to 4 with chance 1/8, and levels 5 and 6 with chance 1/16.
- R9: A step with chance 1/2^k is taken exactly when bits k-1..0 of the shift register value before that update's advance are all zero.
- R10: The shift register shifts left once per update (upd_en_i=1), in every mode and for either outcome, with new bit 0 equal to the XOR of bits 15, 13, 12 and 10. It holds in cycles without an update.
- R11: An update changes only the addressed counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| seed_i | input | 16 | Shift register seed, sampled during reset |
| mode_i | input | 2 | 0/3 plain, 1 retire-squash profile, 2 replay profile |
| rd_en_i | input | 1 | Lookup request |
| rd_idx_i | input | 5 | Lookup index |
| rd_valid_o | output | 1 | Lookup result valid (one cycle after request) |
| rd_level_o | output | 3 | Counter level of the looked-up entry |
| rd_conf_o | output | 1 | Entry is saturated; its prediction may be used |
| upd_en_i | input | 1 | Outcome report valid |
| upd_idx_i | input | 5 | Index of the reported entry |
| upd_hit_i | input | 1 | 1 = prediction was correct, 0 = wrong |

## Verification
The bench chases the draw sequence. A design that tested the register after advancing it, or that advanced it in idle cycles or only on correct outcomes, falls out of step with the reference within a few updates and shows a wrong level. A read and an update aimed at the same entry in the same cycle would expose a design that forwards the new level. Long runs in both probability profiles cross the level-4 to level-5 boundary, where a wrong mask width changes how long saturation takes. A seed of zero would freeze a design that does not replace it, because the register would never leave zero and no step above level 0 would ever be refused.

// File: rtl/cc_pkg.sv
package cc_pkg;

   typedef enum logic [1:0] {
      CC_PLAIN     = 2'd0,
      CC_COMMIT    = 2'd1,
      CC_REISSUE   = 2'd2,
      CC_PLAIN_ALT = 2'd3
   } cc_mode_e;

   localparam int unsigned CC_LVL_W = 3;
   localparam logic [CC_LVL_W-1:0] CC_LVL_MAX = '1;

endpackage

// File: rtl/cc_lfsr.sv
module cc_lfsr #(
   parameter int unsigned W    = 16,
   parameter logic [W-1:0] TAPS = 16'hB400
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] seed,
   input  logic         adv,
   output logic [W-1:0] state_o
);

   if (W < 2) begin : g_bad_w
      $error("cc_lfsr: width must be at least 2");
   end
   if (TAPS == '0) begin : g_bad_taps
      $error("cc_lfsr: tap mask must be nonzero");
   end

   logic [W-1:0] state_q;
   logic [W-1:0] seed_eff;
   logic         fb;

   assign seed_eff = (seed == '0) ? W'(1) : seed;
   assign fb       = ^(state_q & TAPS);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= seed_eff;
      end else if (adv) begin
         state_q <= {state_q[W-2:0], fb};
      end
   end

   assign state_o = state_q;

endmodule

// File: rtl/cc_step.sv
module cc_step
   import cc_pkg::*;
#(
   parameter int unsigned RW      = 16,
   parameter bit          PROB_EN = 1'b1,
   parameter int unsigned A_LO_K  = 4,
   parameter int unsigned A_HI_K  = 5,
   parameter int unsigned B_LO_K  = 3,
   parameter int unsigned B_HI_K  = 4,
   parameter int unsigned HI_FROM = 5
) (
   input  cc_mode_e              mode,
   input  logic [CC_LVL_W-1:0]   lvl,
   input  logic                  hit,
   input  logic [RW-1:0]         rnd,
   output logic [CC_LVL_W-1:0]   nxt
);

   if (A_LO_K > RW || A_HI_K > RW || B_LO_K > RW || B_HI_K > RW) begin : g_bad_k
      $error("cc_step: draw width exceeds random source width");
   end
   if (HI_FROM == 0 || HI_FROM > 6) begin : g_bad_hi
      $error("cc_step: upper band start must lie in 1..6");
   end

   localparam logic [RW-1:0] M_A_LO = RW'((64'd1 << A_LO_K) - 64'd1);
   localparam logic [RW-1:0] M_A_HI = RW'((64'd1 << A_HI_K) - 64'd1);
   localparam logic [RW-1:0] M_B_LO = RW'((64'd1 << B_LO_K) - 64'd1);
   localparam logic [RW-1:0] M_B_HI = RW'((64'd1 << B_HI_K) - 64'd1);
   localparam logic [CC_LVL_W-1:0] HI_LVL = CC_LVL_W'(HI_FROM);

   logic pass;

   if (PROB_EN) begin : g_prob
      logic [RW-1:0] mask;
      logic          upper;
      assign upper = (lvl >= HI_LVL);
      always_comb begin
         mask = '0;
         if (lvl != '0) begin
            unique case (mode)
               CC_COMMIT:  mask = upper ? M_A_HI : M_A_LO;
               CC_REISSUE: mask = upper ? M_B_HI : M_B_LO;
               default:    mask = '0;
            endcase
         end
      end
      assign pass = ((rnd & mask) == '0);
   end else begin : g_plain
      logic unused_rnd;
      assign unused_rnd = ^{rnd, mode};
      assign pass = 1'b1;
   end

   always_comb begin
      if (!hit) begin
         nxt = '0;
      end else if (lvl == CC_LVL_MAX) begin
         nxt = CC_LVL_MAX;
      end else if (pass) begin
         nxt = lvl + CC_LVL_W'(1);
      end else begin
         nxt = lvl;
      end
   end

endmodule

// File: rtl/cc_bank.sv
module cc_bank #(
   parameter int unsigned N  = 32,
   parameter int unsigned IW = 5,
   parameter int unsigned CW = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [IW-1:0]   widx,
   input  logic [CW-1:0]   wdata,
   output logic [N*CW-1:0] flat_o
);

   if (N != (1 << IW)) begin : g_bad_n
      $error("cc_bank: entry count must equal 2**IW");
   end

   for (genvar i = 0; i < N; i++) begin : g_ent
      logic [CW-1:0] cell_q;
      logic          sel;
      assign sel = we && (widx == IW'(i));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cell_q <= '0;
         end else if (sel) begin
            cell_q <= wdata;
         end
      end
      assign flat_o[i*CW +: CW] = cell_q;
   end

endmodule

// File: rtl/conf_ctr_bank.sv
module conf_ctr_bank
   import cc_pkg::*;
#(
   parameter int unsigned N_ENTRIES = 32,
   parameter int unsigned RND_W     = 16,
   parameter logic [RND_W-1:0] RND_TAPS = 16'hB400,
   parameter bit          PROB_EN   = 1'b1,
   parameter int unsigned A_LO_K    = 4,
   parameter int unsigned A_HI_K    = 5,
   parameter int unsigned B_LO_K    = 3,
   parameter int unsigned B_HI_K    = 4,
   parameter int unsigned HI_FROM   = 5,
   localparam int unsigned IDX_W    = $clog2(N_ENTRIES)
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic [RND_W-1:0]     seed_i,
   input  logic [1:0]           mode_i,
   input  logic                 rd_en_i,
   input  logic [IDX_W-1:0]     rd_idx_i,
   output logic                 rd_valid_o,
   output logic [CC_LVL_W-1:0]  rd_level_o,
   output logic                 rd_conf_o,
   input  logic                 upd_en_i,
   input  logic [IDX_W-1:0]     upd_idx_i,
   input  logic                 upd_hit_i
);

   localparam int unsigned LW = CC_LVL_W;

   if (N_ENTRIES < 2) begin : g_bad_entries
      $error("conf_ctr_bank: need at least two entries");
   end

   logic [N_ENTRIES*LW-1:0] ctr_flat;
   logic [RND_W-1:0]        lfsr_q;
   logic [LW-1:0]           upd_cur;
   logic [LW-1:0]           upd_nxt;
   logic [LW-1:0]           rd_cur;
   cc_mode_e                mode;

   assign mode    = cc_mode_e'(mode_i);
   assign upd_cur = ctr_flat[int'(upd_idx_i)*LW +: LW];
   assign rd_cur  = ctr_flat[int'(rd_idx_i)*LW +: LW];

   cc_lfsr #(
      .W    (RND_W),
      .TAPS (RND_TAPS)
   ) u_lfsr (
      .clk     (clk_i),
      .rst_n   (rst_ni),
      .seed    (seed_i),
      .adv     (upd_en_i),
      .state_o (lfsr_q)
   );

   cc_step #(
      .RW      (RND_W),
      .PROB_EN (PROB_EN),
      .A_LO_K  (A_LO_K),
      .A_HI_K  (A_HI_K),
      .B_LO_K  (B_LO_K),
      .B_HI_K  (B_HI_K),
      .HI_FROM (HI_FROM)
   ) u_step (
      .mode (mode),
      .lvl  (upd_cur),
      .hit  (upd_hit_i),
      .rnd  (lfsr_q),
      .nxt  (upd_nxt)
   );

   cc_bank #(
      .N  (N_ENTRIES),
      .IW (IDX_W),
      .CW (LW)
   ) u_bank (
      .clk    (clk_i),
      .rst_n  (rst_ni),
      .we     (upd_en_i),
      .widx   (upd_idx_i),
      .wdata  (upd_nxt),
      .flat_o (ctr_flat)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         rd_valid_o <= 1'b0;
         rd_level_o <= '0;
         rd_conf_o  <= 1'b0;
      end else begin
         rd_valid_o <= rd_en_i;
         if (rd_en_i) begin
            rd_level_o <= rd_cur;
            rd_conf_o  <= (rd_cur == CC_LVL_MAX);
         end
      end
   end

endmodule

// File: rtl/cc_bank_chk.sv
module cc_bank_chk #(
   parameter int unsigned N  = 32,
   parameter int unsigned IW = 5,
   parameter int unsigned CW = 3,
   parameter int unsigned RW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          upd_en,
   input logic [IW-1:0] upd_idx,
   input logic          upd_hit,
   input logic [1:0]    mode,
   input logic [RW-1:0] lfsr,
   input logic [N*CW-1:0] ctr_flat
);

   logic          en_q;
   logic          hit_q;
   logic [1:0]    mode_q;
   logic [IW-1:0] idx_q;
   logic [CW-1:0] old_q;
   logic [CW-1:0] at_idx;
   logic [CW-1:0] cur_at_upd;
   logic          plain_q;

   assign cur_at_upd = ctr_flat[int'(upd_idx)*CW +: CW];
   assign at_idx     = ctr_flat[int'(idx_q)*CW +: CW];
   assign plain_q    = (mode_q == 2'd0) || (mode_q == 2'd3);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         hit_q  <= 1'b0;
         mode_q <= 2'd0;
         idx_q  <= '0;
         old_q  <= '0;
      end else begin
         en_q   <= upd_en;
         hit_q  <= upd_hit;
         mode_q <= mode;
         idx_q  <= upd_idx;
         old_q  <= cur_at_upd;
      end
   end

   // R4
   miss_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && !hit_q) |-> (at_idx == '0));

   // R5
   sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && hit_q && old_q == '1) |-> (at_idx == '1));

   // R6
   plain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && hit_q && plain_q && old_q != '1) |-> (at_idx == old_q + CW'(1)));

   // R9
   hit_no_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && hit_q && old_q != '1) |-> (at_idx == old_q || at_idx == old_q + CW'(1)));

   // R7
   first_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && hit_q && old_q == '0) |-> (at_idx == CW'(1)));

   // R10
   lfsr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_en |=> $stable(lfsr));

   // R1
   lfsr_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lfsr != '0);

endmodule

bind conf_ctr_bank cc_bank_chk #(
   .N  (N_ENTRIES),
   .IW (IDX_W),
   .CW (cc_pkg::CC_LVL_W),
   .RW (RND_W)
) u_chk (
   .clk      (clk_i),
   .rst_n    (rst_ni),
   .upd_en   (upd_en_i),
   .upd_idx  (upd_idx_i),
   .upd_hit  (upd_hit_i),
   .mode     (mode_i),
   .lfsr     (lfsr_q),
   .ctr_flat (ctr_flat)
);

// File: tb/sim_conf_ctr_bank.sv
`timescale 1ns/1ps
module sim_conf_ctr_bank;

   localparam int NE = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] seed = 16'h0;
   logic [1:0]  mode = 2'd0;
   logic        rd_en = 1'b0;
   logic [4:0]  rd_idx = '0;
   logic        rd_valid;
   logic [2:0]  rd_level;
   logic        rd_conf;
   logic        upd_en = 1'b0;
   logic [4:0]  upd_idx = '0;
   logic        upd_hit = 1'b0;

   int checks = 0;
   int errors = 0;
   int ref_ctr[NE];
   int ref_l;
   int sat_seen;

   always #2 clk = ~clk;

   conf_ctr_bank u0 (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .seed_i     (seed),
      .mode_i     (mode),
      .rd_en_i    (rd_en),
      .rd_idx_i   (rd_idx),
      .rd_valid_o (rd_valid),
      .rd_level_o (rd_level),
      .rd_conf_o  (rd_conf),
      .upd_en_i   (upd_en),
      .upd_idx_i  (upd_idx),
      .upd_hit_i  (upd_hit)
   );

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic int draw_bits(input int m, input int lv);
      if (lv == 0 || lv == 7) return 0;
      if (m == 1) return (lv >= 5) ? 5 : 4;
      if (m == 2) return (lv >= 5) ? 4 : 3;
      return 0;
   endfunction

   function automatic void model_upd(input int idx, input bit hit);
      int k;
      int fb;
      if (!hit) begin
         ref_ctr[idx] = 0;
      end else if (ref_ctr[idx] < 7) begin
         k = draw_bits(int'(mode), ref_ctr[idx]);
         if ((ref_l & ((1 << k) - 1)) == 0) ref_ctr[idx] = ref_ctr[idx] + 1;
      end
      fb = ((ref_l >> 15) ^ (ref_l >> 13) ^ (ref_l >> 12) ^ (ref_l >> 10)) & 1;
      ref_l = ((ref_l << 1) | fb) & 16'hFFFF;
   endfunction

   // One clock: drive, advance the model, compare after the edge.
   task automatic step(input string tag, input bit re, input int ri,
                       input bit ue, input int ui, input bit uh);
      int exp_lv;
      rd_en   = re;
      rd_idx  = 5'(ri);
      upd_en  = ue;
      upd_idx = 5'(ui);
      upd_hit = uh;
      exp_lv  = ref_ctr[ri];
      if (ue) model_upd(ui, uh);
      @(posedge clk);
      @(negedge clk);
      chk("R2", "rd_valid", int'(rd_valid), int'(re));
      if (re) begin
         chk(tag, "rd_level", int'(rd_level), exp_lv);
         chk("R2", "rd_conf", int'(rd_conf), (exp_lv == 7) ? 1 : 0);
         if (exp_lv == 7) sat_seen++;
      end
   endtask

   task automatic do_reset(input logic [15:0] s);
      rst_n  = 1'b0;
      seed   = s;
      rd_en  = 1'b0;
      upd_en = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < NE; i++) ref_ctr[i] = 0;
      ref_l = (s == 16'h0) ? 1 : int'(s);
      chk("R1", "rd_valid after reset", int'(rd_valid), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      @(negedge clk);
      // R1: reset state of every entry
      do_reset(16'hACE1);
      for (int i = 0; i < NE; i++) step("R1", 1'b1, i, 1'b0, 0, 1'b0);
      step("R2", 1'b0, 0, 1'b0, 0, 1'b0);

      // R6 / R3: plain mode, read same entry while updating
      mode = 2'd0;
      for (int i = 0; i < 7; i++) step("R3", 1'b1, 3, 1'b1, 3, 1'b1);
      step("R6", 1'b1, 3, 1'b0, 0, 1'b0);
      // R5: saturated entry stays
      step("R5", 1'b1, 3, 1'b1, 3, 1'b1);
      step("R5", 1'b1, 3, 1'b0, 0, 1'b0);
      // R11: neighbours untouched
      step("R11", 1'b1, 4, 1'b0, 0, 1'b0);
      step("R11", 1'b1, 2, 1'b0, 0, 1'b0);
      // R4: miss clears from 7, same-cycle read sees 7 (R3)
      step("R3", 1'b1, 3, 1'b1, 3, 1'b0);
      step("R4", 1'b1, 3, 1'b0, 0, 1'b0);
      // R4 from a middle level
      for (int i = 0; i < 4; i++) step("R6", 1'b0, 0, 1'b1, 6, 1'b1);
      step("R6", 1'b1, 6, 1'b0, 0, 1'b0);
      step("R4", 1'b0, 0, 1'b1, 6, 1'b0);
      step("R4", 1'b1, 6, 1'b0, 0, 1'b0);

      // R7 / R9 / R10: retire-squash profile with idle gaps and misses elsewhere
      do_reset(16'hACE1);
      mode = 2'd1;
      sat_seen = 0;
      for (int i = 0; i < 600; i++) begin
         if (i % 7 == 3)       step("R10", 1'b1, 5, 1'b0, 0, 1'b0);
         else if (i % 11 == 5) step("R11", 1'b1, 5, 1'b1, 8, 1'b0);
         else                  step("R7", 1'b1, 5, 1'b1, 5, 1'b1);
      end
      chk("R7", "entry 5 reached saturation", (ref_ctr[5] == 7) ? 1 : 0, 1);

      // R8 / R9: replay profile on two entries with periodic misses
      mode = 2'd2;
      for (int i = 0; i < 500; i++) begin
         if (i % 97 == 96)   step("R4", 1'b1, 9, 1'b1, 9, 1'b0);
         else if (i % 2 == 0) step("R8", 1'b1, 9, 1'b1, 9, 1'b1);
         else                 step("R9", 1'b1, 10, 1'b1, 10, 1'b1);
      end

      // R6: mode 3 behaves as plain
      mode = 2'd3;
      for (int i = 0; i < 9; i++) step("R6", 1'b1, 12, 1'b1, 12, 1'b1);
      step("R6", 1'b1, 12, 1'b0, 0, 1'b0);

      // R1: zero seed replaced by 1, then profile run still follows the model
      do_reset(16'h0000);
      mode = 2'd1;
      for (int i = 0; i < 300; i++) step("R1", 1'b1, 20, 1'b1, 20, 1'b1);
      mode = 2'd2;
      for (int i = 0; i < 200; i++) step("R9", 1'b1, 21, 1'b1, 21, 1'b1);
      for (int i = 0; i < NE; i++) step("R11", 1'b1, i, 1'b0, 0, 1'b0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule